// File: doc/BRIEF.md
# Interrupt Flag Merge and Vector Select

This block holds every interrupt flag of a small controller, folds the flags that belong to one peripheral into a single request per source, and picks one request by fixed priority. While a request is outstanding it shows the CPU a 16-bit vector address. When the CPU acknowledges that vector, it clears the flag of those sources whose flags are cleared by hardware. All other flags stay set until software writes them to zero.

Peripherals raise flags with one-cycle set pulses. Eight general-purpose pins set their own flags, either on a rising edge or for as long as the pin is high. Software reaches the flags through a small write port: a source index plus a data byte whose low bits replace that source's flags. This lets software raise a request or cancel one. A global enable and one enable per source gate the requests. The enables never touch the stored flags.

Top module: `irq_vectoring`

## Requirements
- R1: While rst_ni is low, and right after it is released, irq_o is 0, vec_o is 0x0000 and all flag_o bits are 0.
- R2: There are ten sources, numbered 0 to 9. Their flags sit in flag_o as follows:
  - source 0, external 0: bit 0
  - source 1, timer 0: bit 1
  - source 2, external 1: bit 2
  - source 3, timer 1: bit 3
  - source 4, serial: bits 5:4
  - source 5, timer 2: bits 7:6
  - source 6, comparator: bits 9:8
  - source 7, general-purpose pins: bits 17:10
  - source 8, capture/compare: bits 21:18
  - source 9, SPI: bits 24:22

  Any set flag of a source forms that source's request. The vector of source n is 0x0003 + 8*n, which gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B, 0x0033, 0x003B, 0x0043 and 0x004B. vec_o reads 0x0000 while irq_o is low.
- R3: When several enabled requests are pending, the source with the lowest index (lowest vector) is presented.
- R4: A request is taken only when gie_i and src_en_i[n] are both high. A gated source keeps its flags set, and its request is taken on the first edge after it is enabled.
- R5: An acknowledge clears the flag of timer 0 (bit 1) or timer 1 (bit 3) when that source is the one presented. An acknowledge leaves the flags of every other source untouched.
- R6: A write with sw_we_i high and sw_sel_i = n loads the low bits of sw_wdata_i into source n's flags, in the bit order given in R2. A 1 sets a flag and a 0 clears it.
- R7: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: When gp_level_i[k] is high, flag 10+k is set on every edge at which gp_pin_i[k] is high, so a software clear has no effect while the pin stays high. When gp_level_i[k] is low, a rising edge on the pin sets the flag once, and software can then clear it while the pin is still high.
- R9: Once irq_o is high, vec_o holds its value until the edge that samples ack_i high, even if a higher-priority request arrives. irq_o is low in the cycle after that acknowledge. It rises again one cycle later if a request is still pending.
- R10: A flag is set at the first clock edge that samples its set. irq_o rises at the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gie_i | input | 1 | Global interrupt enable |
| src_en_i | input | 10 | One enable per source |
| hw_set_i | input | 25 | Hardware set pulse per flag |
| gp_pin_i | input | 8 | General-purpose interrupt pins |
| gp_level_i | input | 8 | 1 = level-sensitive pin, 0 = rising edge |
| sw_we_i | input | 1 | Software flag write strobe |
| sw_sel_i | input | 4 | Source index of the write |
| sw_wdata_i | input | 8 | New flag values, in the low bits |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector address of the held request |
| flag_o | output | 25 | Readback of all flags |

## Verification
A flag write or set pulse shows on flag_o one edge later. A new request shows on irq_o and vec_o one edge after that. An acknowledge lowers irq_o one edge later, and any remaining request comes back on the following edge. The bench drives its inputs on falling edges and counts rising edges to reach each result. It samples at the falling edge on which the result is first due, and in the cycles just before that, so that a result arriving early or late is caught.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC = 10;
  localparam int MAXW = 8;
  localparam int SRC_W [NSRC] = '{1, 1, 1, 1, 2, 2, 2, 8, 4, 3};
  localparam logic [NSRC-1:0] SRC_AUTO = 10'b00_0000_1010;
  localparam int GP_SRC = 7;
  localparam int SELW = $clog2(NSRC);

  function automatic int src_off(input int s);
    int o = 0;
    for (int i = 0; i < s; i++) o += SRC_W[i];
    return o;
  endfunction

  localparam int NF = src_off(NSRC);
  localparam int GP_OFF = src_off(GP_SRC);
  localparam int GPW = SRC_W[GP_SRC];

  function automatic int flag_src(input int b);
    for (int s = 0; s < NSRC; s++)
      if (b >= src_off(s) && b < src_off(s) + SRC_W[s]) return s;
    return 0;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_vec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NF-1:0]   hw_set_i,
  input  logic [GPW-1:0]  gp_pin_i,
  input  logic [GPW-1:0]  gp_level_i,
  input  logic            sw_we_i,
  input  logic [SELW-1:0] sw_sel_i,
  input  logic [MAXW-1:0] sw_wdata_i,
  input  logic [NSRC-1:0] ack_clr_i,
  output logic [NF-1:0]   flag_o
);
  logic [GPW-1:0] pin_q;
  logic [GPW-1:0] gp_set;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= gp_pin_i;

  // level pins set every cycle they are high; edge pins only on a rise
  assign gp_set = (gp_level_i & gp_pin_i) | (~gp_level_i & gp_pin_i & ~pin_q);

  for (genvar b = 0; b < NF; b++) begin : g_flag
    localparam int S = flag_src(b);
    localparam int L = b - src_off(S);
    logic set_b;
    if (S == GP_SRC) begin : g_gp
      assign set_b = hw_set_i[b] | gp_set[L];
    end else begin : g_pl
      assign set_b = hw_set_i[b];
    end
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                    flag_o[b] <= 1'b0;
      else if (set_b)                                 flag_o[b] <= 1'b1;
      else if (sw_we_i && sw_sel_i == SELW'(S))       flag_o[b] <= sw_wdata_i[L];
      else if (ack_clr_i[S])                          flag_o[b] <= 1'b0;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
(
  input  logic [NF-1:0]   flag_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic            gie_i,
  output logic            any_o,
  output logic [SELW-1:0] win_o
);
  logic [NSRC-1:0] req;

  for (genvar s = 0; s < NSRC; s++) begin : g_req
    localparam int OFF = src_off(s);
    localparam int W = SRC_W[s];
    assign req[s] = gie_i & src_en_i[s] & (|flag_i[OFF +: W]);
  end

  assign any_o = |req;

  always_comb begin
    win_o = '0;
    for (int s = NSRC - 1; s >= 0; s--)
      if (req[s]) win_o = SELW'(s);
  end
endmodule

// File: rtl/irq_vec_hold.sv
module irq_vec_hold
  import irq_vec_pkg::*;
#(
  parameter int VW = 16,
  parameter logic [VW-1:0] VBASE = 16'h0003,
  parameter int VSTEP = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            any_i,
  input  logic [SELW-1:0] win_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [VW-1:0]   vec_o,
  output logic [NSRC-1:0] ack_clr_o
);
  logic            irq_q;
  logic [SELW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      irq_q <= 1'b0;
      sel_q <= '0;
    end else if (irq_q) begin
      if (ack_i) irq_q <= 1'b0;
    end else if (any_i) begin
      irq_q <= 1'b1;
      sel_q <= win_i;
    end

  assign irq_o = irq_q;
  assign vec_o = irq_q ? VBASE + VW'(VSTEP) * VW'(sel_q) : '0;

  for (genvar s = 0; s < NSRC; s++) begin : g_clr
    if (SRC_AUTO[s]) begin : g_auto
      assign ack_clr_o[s] = irq_q & ack_i & (sel_q == SELW'(s));
    end else begin : g_keep
      assign ack_clr_o[s] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_vectoring.sv
module irq_vectoring
  import irq_vec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            gie_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic [NF-1:0]   hw_set_i,
  input  logic [GPW-1:0]  gp_pin_i,
  input  logic [GPW-1:0]  gp_level_i,
  input  logic            sw_we_i,
  input  logic [SELW-1:0] sw_sel_i,
  input  logic [MAXW-1:0] sw_wdata_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [15:0]     vec_o,
  output logic [NF-1:0]   flag_o
);
  logic [NSRC-1:0] ack_clr;
  logic            any;
  logic [SELW-1:0] win;

  irq_flag_bank u_bank (
    .clk_i, .rst_ni, .hw_set_i, .gp_pin_i, .gp_level_i,
    .sw_we_i, .sw_sel_i, .sw_wdata_i,
    .ack_clr_i(ack_clr), .flag_o
  );

  irq_arbiter u_arb (
    .flag_i(flag_o), .src_en_i, .gie_i, .any_o(any), .win_o(win)
  );

  irq_vec_hold #(.VW(16), .VBASE(16'h0003), .VSTEP(8)) u_hold (
    .clk_i, .rst_ni, .any_i(any), .win_i(win), .ack_i,
    .irq_o, .vec_o, .ack_clr_o(ack_clr)
  );
endmodule

// File: rtl/irq_vectoring_chk.sv
module irq_vectoring_chk
  import irq_vec_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           gie_i,
  input logic [NF-1:0]  hw_set_i,
  input logic [GPW-1:0] gp_pin_i,
  input logic [GPW-1:0] gp_level_i,
  input logic           sw_we_i,
  input logic           ack_i,
  input logic           irq_o,
  input logic [15:0]    vec_o,
  input logic [NF-1:0]  flag_o
);
  assert_vec_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[2:0] == 3'b011 && vec_o <= 16'h004B));

  assert_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !gie_i) |=> !irq_o);

  assert_t0_autoclr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i && vec_o == 16'h000B && !hw_set_i[1] && !sw_we_i) |=> !flag_o[1]);

  assert_hw_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set_i) |=> ((flag_o & $past(hw_set_i)) == $past(hw_set_i)));

  assert_level_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(gp_level_i & gp_pin_i)) |=>
      ((flag_o[GP_OFF +: GPW] & $past(gp_level_i & gp_pin_i)) == $past(gp_level_i & gp_pin_i)));

  assert_vec_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

  assert_ack_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> !irq_o);
endmodule

bind irq_vectoring irq_vectoring_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gie_i(gie_i), .hw_set_i(hw_set_i),
  .gp_pin_i(gp_pin_i), .gp_level_i(gp_level_i), .sw_we_i(sw_we_i),
  .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o), .flag_o(flag_o)
);

// File: tb/sim_irq_vectoring.sv
`timescale 1ns/1ps
module sim_irq_vectoring;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        gie = 1'b0;
  logic [9:0]  src_en = '0;
  logic [24:0] hw_set = '0;
  logic [7:0]  gp_pin = '0;
  logic [7:0]  gp_level = '0;
  logic        sw_we = 1'b0;
  logic [3:0]  sw_sel = '0;
  logic [7:0]  sw_wdata = '0;
  logic        ack = 1'b0;
  logic        irq;
  logic [15:0] vec;
  logic [24:0] flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vectoring u0 (
    .clk_i(clk), .rst_ni, .gie_i(gie), .src_en_i(src_en), .hw_set_i(hw_set),
    .gp_pin_i(gp_pin), .gp_level_i(gp_level), .sw_we_i(sw_we), .sw_sel_i(sw_sel),
    .sw_wdata_i(sw_wdata), .ack_i(ack), .irq_o(irq), .vec_o(vec), .flag_o(flag)
  );

  typedef struct packed {
    logic [3:0]  sel;
    logic [7:0]  wd;
    logic [15:0] vec;
    logic [24:0] fset;
    logic [24:0] fack;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{4'd0, 8'h01, 16'h0003, 25'h0000001, 25'h0000001},
    '{4'd1, 8'h01, 16'h000B, 25'h0000002, 25'h0000000},
    '{4'd2, 8'h01, 16'h0013, 25'h0000004, 25'h0000004},
    '{4'd3, 8'h01, 16'h001B, 25'h0000008, 25'h0000000},
    '{4'd4, 8'h02, 16'h0023, 25'h0000020, 25'h0000020},
    '{4'd5, 8'h01, 16'h002B, 25'h0000040, 25'h0000040},
    '{4'd6, 8'h03, 16'h0033, 25'h0000300, 25'h0000300},
    '{4'd7, 8'h80, 16'h003B, 25'h0020000, 25'h0020000},
    '{4'd8, 8'h08, 16'h0043, 25'h0200000, 25'h0200000},
    '{4'd9, 8'h04, 16'h004B, 25'h1000000, 25'h1000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sw_wr(input logic [3:0] sel, input logic [7:0] wd);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = wd;
    tick();
    sw_we = 1'b0;
  endtask

  task automatic pulse(input logic [24:0] bits);
    hw_set = bits;
    tick();
    hw_set = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 irq in reset", 32'(irq), 0);
    chk("R1 vec in reset", 32'(vec), 0);
    chk("R1 flags in reset", 32'(flag), 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 flags after release", 32'(flag), 0);
    chk("R1 irq after release", 32'(irq), 0);

    // one source at a time: R2 R5 R6 R9 R10
    src_en = '1;
    gie = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sw_wr(TBL[i].sel, TBL[i].wd);
      chk("R6 flag after write", 32'(flag), 32'(TBL[i].fset));
      chk("R10 irq not yet", 32'(irq), 0);
      tick();
      chk("R10 irq raised", 32'(irq), 1);
      chk("R2 vector", 32'(vec), 32'(TBL[i].vec));
      ack = 1'b1; gie = 1'b0;
      tick();
      ack = 1'b0;
      chk("R9 irq drops after ack", 32'(irq), 0);
      chk("R5 flags after ack", 32'(flag), 32'(TBL[i].fack));
      sw_wr(TBL[i].sel, 8'h00);
      chk("R6 flag cleared", 32'(flag), 0);
      gie = 1'b1;
    end

    // R3 priority, R9 re-raise
    pulse(25'h0000014);
    chk("R10 irq low after first edge", 32'(irq), 0);
    tick();
    chk("R3 lower vector wins", 32'(vec), 32'h0013);
    ack = 1'b1;
    sw_wr(4'd2, 8'h00);
    ack = 1'b0;
    chk("R9 drop after ack", 32'(irq), 0);
    tick();
    chk("R9 re-raise pending", 32'(irq), 1);
    chk("R3 next source", 32'(vec), 32'h0023);
    ack = 1'b1; gie = 1'b0;
    tick();
    ack = 1'b0;
    sw_wr(4'd4, 8'h00);
    chk("R3 flags clean", 32'(flag), 0);

    // R4 gating
    pulse(25'h1000000);
    tick();
    chk("R4 gie low blocks", 32'(irq), 0);
    gie = 1'b1; src_en[9] = 1'b0;
    tick(); tick();
    chk("R4 source disabled blocks", 32'(irq), 0);
    chk("R4 flag kept pending", 32'(flag), 32'h1000000);
    src_en[9] = 1'b1;
    tick();
    chk("R4 taken after enable", 32'(irq), 1);
    chk("R4 vector", 32'(vec), 32'h004B);
    ack = 1'b1; gie = 1'b0;
    tick();
    ack = 1'b0;
    sw_wr(4'd9, 8'h00);

    // R7 set beats clear
    hw_set = 25'h0000020;
    sw_wr(4'd4, 8'h00);
    hw_set = '0;
    chk("R7 hw set wins", 32'(flag), 32'h20);
    sw_wr(4'd4, 8'h00);
    chk("R7 later clear works", 32'(flag), 0);

    // R8 level and edge pins
    gp_level[2] = 1'b1; gp_pin[2] = 1'b1;
    tick();
    chk("R8 level sets", 32'(flag), 32'h1000);
    sw_wr(4'd7, 8'h00);
    chk("R8 clear ignored while high", 32'(flag), 32'h1000);
    gp_pin[2] = 1'b0;
    sw_wr(4'd7, 8'h00);
    chk("R8 clear after pin low", 32'(flag), 0);
    gp_pin[3] = 1'b1;
    tick();
    chk("R8 edge sets", 32'(flag), 32'h2000);
    tick();
    sw_wr(4'd7, 8'h00);
    chk("R8 edge flag clears while high", 32'(flag), 0);
    gp_pin[3] = 1'b0;
    tick();

    // R9 vector held against higher priority
    gie = 1'b1;
    pulse(25'h0020000);
    tick();
    chk("R9 initial vector", 32'(vec), 32'h003B);
    pulse(25'h0000001);
    tick();
    chk("R9 held vector", 32'(vec), 32'h003B);
    chk("R9 irq still high", 32'(irq), 1);
    ack = 1'b1;
    sw_wr(4'd7, 8'h00);
    ack = 1'b0;
    chk("R9 drop after ack", 32'(irq), 0);
    tick();
    chk("R9 new winner", 32'(vec), 32'h0003);
    ack = 1'b1; gie = 1'b0;
    tick();
    ack = 1'b0;
    sw_wr(4'd0, 8'h00);
    chk("R9 flags clean", 32'(flag), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule